// File: doc/BRIEF.md
# Backlight PWM Generator with Staged Settings

This block drives a single display backlight line with a pulse-width-modulated waveform. Software programs it through a small memory-mapped port that has an address, a write strobe, write data and combinational read data. A prescaler divides the input clock into ticks. A period counter counts ticks to form one output cycle. A comparator holds the output high for the programmed number of ticks at the start of each cycle.

The prescaler, period and high-width settings are first written into staging (shadow) registers, which do not affect the output. Writing 1 to the commit bit marks the staged values for transfer. The active (working) registers take them over at the next output-cycle boundary, so no cycle is ever cut short. A two-bit debug control can bypass the staging: with both bits set, the working registers follow every write directly. A separate enable bit gates the output.

Top module: `bl_pwm`

## Requirements
- R1: After reset the output is low and every register reads back as zero.
- R2: Registers read back their stored contents, with all unused bits zero:
  - enable bit 0 at 0x00;
  - commit bit 0 at 0x08;
  - prescaler in bits [25:16] of 0x10;
  - period in bits [11:0] of 0x14;
  - high width in bits [28:16] of 0x14;
  - debug bits [1:0] at 0x80.
- R3: While the enable bit is 0, the output is held low.
- R4: With working prescaler D, period P and high width H, where 0 < H <= P+1, one output cycle lasts (D+1)*(P+1) clocks, of which (D+1)*H are high.
- R5: A high width of zero gives a constant low output. A high width of P+1 or more gives a constant high output.
- R6: Writes to the prescaler or period/high-width registers do not change the waveform until a commit, when bypass is off.
- R7: A 0-to-1 transition of the commit bit loads the staged settings at the next cycle boundary. The running cycle completes at its old length, and the following cycle uses the new values.
- R8: With debug bits [1:0] = 2'b11, the working settings follow register writes without a commit. With only one of the two bits set, staging stays in force.
- R9: When the enable bit goes from 0 to 1, the counters start from zero. The output is high in the first clock after the enabling write exactly when the high width is nonzero.
- R10: Holding the commit bit at 1 does not transfer settings that are written afterwards. Only a new 0-to-1 transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
- **Register reads.** A write is visible on reg_rdata right after the clock edge that samples it. The bench therefore reads one negative edge after each write.
- **Enable.** The output level changes right after the enabling edge, since pwm_out is decoded from registered counters. The first sample is taken at the negative edge following that edge.
- **Commit.** A commit needs one cycle for the commit bit and one for the pending flag, and then waits for a cycle boundary. In bypass, the working copy trails a write by one further cycle. Steady-state checks therefore wait at least one full output period before counting high samples over a window exactly one period long; such a window gives the high time whatever its phase.
- **No truncation.** The commit is written one clock after a falling edge of the output. The bench then counts the remaining low run, the next high run and the next low run, which must match the old period and then the new one.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int DIV_W = 10;
  localparam int PER_W = 12;
  localparam int HI_W  = 13;

  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [PER_W-1:0] per;
    logic [DIV_W-1:0] div;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] A_EN  = 'h00,
  parameter logic [ADDR_W-1:0] A_CM  = 'h08,
  parameter logic [ADDR_W-1:0] A_C0  = 'h10,
  parameter logic [ADDR_W-1:0] A_C1  = 'h14,
  parameter logic [ADDR_W-1:0] A_DBG = 'h80,
  parameter int DIV_LSB = 16,
  parameter int PER_LSB = 0,
  parameter int HI_LSB  = 16,
  parameter int DBG_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output pwm_cfg_t          shadow,
  output logic              en,
  output logic              cm_bit,
  output logic              bypass
);
  localparam int DIV_MSB = DIV_LSB + DIV_W - 1;
  localparam int PER_MSB = PER_LSB + PER_W - 1;
  localparam int HI_MSB  = HI_LSB + HI_W - 1;

  pwm_cfg_t         sh_q, sh_d;
  logic             en_q, en_d, cm_q, cm_d;
  logic [DBG_W-1:0] dbg_q, dbg_d;

  always_comb begin
    sh_d  = sh_q;
    en_d  = en_q;
    cm_d  = cm_q;
    dbg_d = dbg_q;
    if (wr) begin
      unique case (addr)
        A_EN:    en_d  = wdata[0];
        A_CM:    cm_d  = wdata[0];
        A_C0:    sh_d.div = wdata[DIV_MSB:DIV_LSB];
        A_C1: begin
          sh_d.per = wdata[PER_MSB:PER_LSB];
          sh_d.hi  = wdata[HI_MSB:HI_LSB];
        end
        A_DBG:   dbg_d = wdata[DBG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      en_q  <= 1'b0;
      cm_q  <= 1'b0;
      dbg_q <= '0;
    end else begin
      sh_q  <= sh_d;
      en_q  <= en_d;
      cm_q  <= cm_d;
      dbg_q <= dbg_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_EN:    rdata[0] = en_q;
      A_CM:    rdata[0] = cm_q;
      A_C0:    rdata[DIV_MSB:DIV_LSB] = sh_q.div;
      A_C1: begin
        rdata[PER_MSB:PER_LSB] = sh_q.per;
        rdata[HI_MSB:HI_LSB]   = sh_q.hi;
      end
      A_DBG:   rdata[DBG_W-1:0] = dbg_q;
      default: ;
    endcase
  end

  assign shadow = sh_q;
  assign en     = en_q;
  assign cm_bit = cm_q;
  assign bypass = &dbg_q;
endmodule

// File: rtl/bl_pwm_xfer.sv
module bl_pwm_xfer
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_cfg_t shadow,
  input  logic     cm_bit,
  input  logic     bypass,
  input  logic     run,
  input  logic     cyc_end,
  output pwm_cfg_t work
);
  pwm_cfg_t work_q, work_d;
  logic     cm_prev_q, pend_q, pend_d;
  logic     cm_rise, load;

  assign cm_rise = cm_bit & ~cm_prev_q;
  assign load    = bypass | (pend_q & (cyc_end | ~run));

  always_comb begin
    pend_d = cm_rise | (pend_q & ~load);
    work_d = load ? shadow : work_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q    <= '0;
      cm_prev_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      work_q    <= work_d;
      cm_prev_q <= cm_bit;
      pend_q    <= pend_d;
    end
  end

  assign work = work_q;

  // R7
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && run && !cyc_end) |=> $stable(work_q));

  // R10
  pend_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(cm_bit && !cm_prev_q)) |=> !pend_q);
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  pwm_cfg_t work,
  output logic     cyc_end,
  output logic     pwm_out
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             tick;

  assign tick    = pre_q >= work.div;
  assign cyc_end = run & tick & (per_q >= work.per);

  always_comb begin
    pre_d = pre_q;
    per_d = per_q;
    if (!run) begin
      pre_d = '0;
      per_d = '0;
    end else if (tick) begin
      pre_d = '0;
      per_d = cyc_end ? '0 : per_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end

  assign pwm_out = run & ({1'b0, per_q} < work.hi);

  // R5
  zero_width_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (work.hi == '0) |-> !pwm_out);

  // R9
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (pwm_out == (work.hi != '0)));
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic     rst_meta_q, rst_sync_q;
  pwm_cfg_t shadow, work;
  logic     en, cm_bit, bypass, cyc_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bl_pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .shadow(shadow), .en(en),
    .cm_bit(cm_bit), .bypass(bypass)
  );

  bl_pwm_xfer u_xfer (
    .clk(clk), .rst_n(rst_sync_q), .shadow(shadow), .cm_bit(cm_bit),
    .bypass(bypass), .run(en), .cyc_end(cyc_end), .work(work)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_sync_q), .run(en), .work(work),
    .cyc_end(cyc_end), .pwm_out(pwm_out)
  );

  // R3
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !en |-> !pwm_out);
endmodule

// File: tb/bl_pwm_bench.sv
module bl_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [7:0] A_EN = 8'h00, A_CM = 8'h08, A_C0 = 8'h10,
                         A_C1 = 8'h14, A_DBG = 8'h80;

  // {div, period, high, expected clocks per cycle, expected high clocks}
  localparam int VEC [6][5] = '{
    '{0, 9, 3, 10, 3},
    '{2, 4, 2, 15, 6},
    '{1, 3, 0, 8, 0},
    '{0, 5, 9, 6, 6},
    '{3, 2, 3, 12, 12},
    '{1, 7, 8, 16, 16}
  };

  always #4 clk = ~clk;

  bl_pwm u_bl_pwm (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int h, g, lo;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    idle(3);
    chk(pwm_out == 1'b0, "R1 out in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    idle(4);
    // R1: all registers zero
    rd(A_EN, d);  chk(d == 0, "R1 enable", d, 0);
    rd(A_CM, d);  chk(d == 0, "R1 commit", d, 0);
    rd(A_C0, d);  chk(d == 0, "R1 ctrl0", d, 0);
    rd(A_C1, d);  chk(d == 0, "R1 ctrl1", d, 0);
    rd(A_DBG, d); chk(d == 0, "R1 debug", d, 0);
    // R2: readback masks
    wr(A_C0, 32'hFFFF_FFFF);  rd(A_C0, d);  chk(d == 32'h03FF_0000, "R2 ctrl0", d, 32'h03FF_0000);
    wr(A_C1, 32'hFFFF_FFFF);  rd(A_C1, d);  chk(d == 32'h1FFF_0FFF, "R2 ctrl1", d, 32'h1FFF_0FFF);
    wr(A_DBG, 32'hFFFF_FFFE); rd(A_DBG, d); chk(d == 32'h2, "R2 debug", d, 2);
    wr(A_EN, 32'hFFFF_FFFE);  rd(A_EN, d);  chk(d == 32'h0, "R2 enable", d, 0);
    wr(A_DBG, 0);
    // R3: committed nonzero width but disabled
    wr(A_C1, (32'd4 << 16) | 32'd7); wr(A_CM, 1); wr(A_CM, 0); idle(3);
    measure(20, h); chk(h == 0, "R3 disabled low", h, 0);

    // Vector table: R4, R5, R9
    for (int v = 0; v < 6; v++) begin
      wr(A_EN, 0);
      wr(A_C0, VEC[v][0] << 16);
      wr(A_C1, (VEC[v][2] << 16) | VEC[v][1]);
      wr(A_CM, 1); wr(A_CM, 0); idle(3);
      wr(A_EN, 1);
      chk(pwm_out == (VEC[v][2] != 0), "R9 first level", int'(pwm_out), int'(VEC[v][2] != 0));
      measure(VEC[v][3], h);
      chk(h == VEC[v][4], "R4 R5 first cycle high", h, VEC[v][4]);
      measure(VEC[v][3], h);
      chk(h == VEC[v][4], "R4 R5 second cycle high", h, VEC[v][4]);
    end

    // Known running state: div 0, period 9, high 3
    wr(A_EN, 0); wr(A_C0, 0); wr(A_C1, (32'd3 << 16) | 32'd9);
    wr(A_CM, 1); wr(A_CM, 0); idle(3); wr(A_EN, 1);
    measure(10, h); chk(h == 3, "R4 base", h, 3);
    // R6: staged write without commit has no effect
    wr(A_C1, (32'd7 << 16) | 32'd9); idle(20);
    measure(10, h); chk(h == 3, "R6 no commit", h, 3);
    // R8: a single debug bit does not bypass
    wr(A_DBG, 1); idle(20); measure(10, h); chk(h == 3, "R8 dbg=1", h, 3);
    wr(A_DBG, 2); idle(20); measure(10, h); chk(h == 3, "R8 dbg=2", h, 3);
    wr(A_DBG, 0);
    // R7: commit applies staged values
    wr(A_CM, 1); idle(20); measure(10, h); chk(h == 7, "R7 commit", h, 7);
    // R10: commit held high, later writes not transferred
    wr(A_C1, (32'd2 << 16) | 32'd9); idle(20);
    measure(10, h); chk(h == 7, "R10 held commit", h, 7);
    wr(A_CM, 0);
    // R8: bypass with both bits
    wr(A_DBG, 3); idle(12); measure(10, h); chk(h == 2, "R8 bypass", h, 2);
    wr(A_C1, (32'd5 << 16) | 32'd9); idle(12);
    measure(10, h); chk(h == 5, "R8 bypass write", h, 5);
    wr(A_DBG, 0);
    // R7: commit mid-cycle must not truncate the running cycle
    wr(A_C1, (32'd2 << 16) | 32'd5);
    while (!pwm_out) @(negedge clk);
    while (pwm_out) @(negedge clk);
    wr(A_CM, 1);
    g = 1;
    while (!pwm_out && g < 40) begin g++; @(negedge clk); end
    chk(g == 5, "R7 old cycle completes", g, 5);
    h = 0;
    while (pwm_out && h < 40) begin h++; @(negedge clk); end
    chk(h == 2, "R7 new high run", h, 2);
    lo = 0;
    while (!pwm_out && lo < 40) begin lo++; @(negedge clk); end
    chk(lo == 4, "R7 new low run", lo, 4);
    wr(A_CM, 0);
    // R3: disabling while running forces low
    wr(A_EN, 0); measure(12, h); chk(h == 0, "R3 disable", h, 0);
    finish_run();
  end
endmodule